// File: doc/BRIEF.md
# Strided Dot-Product Streaming Unit

This unit computes one counted dot product between two byte vectors held in two separate local memory banks. Each operand is described by a base address and a shape tag. The shape tells the unit how to walk the bank: a fixed single word, a contiguous row, a column of an 8-wide byte matrix, or a whole matrix walked in storage order. Once it accepts a start pulse, the unit issues one read per cycle to each bank. It multiplies the unsigned byte pairs as they return from the synchronous-read memories and keeps a running 16-bit sum.

When the last product has been added, the sum leaves the unit as two bytes on a byte-wide output stream, each byte marked by a valid strobe. A done pulse marks the second byte. A typical use is one row of an 8x8 coefficient matrix against one column of an 8x8 pixel matrix, with the count set to 8. The count can be anything from 0 up to its parameter limit. The unit accepts a new start in the cycle after done.

Top module: `vmac_stream_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid`, `done`, `a_rd_en` and `b_rd_en` are low.
- R2: For a row operand (shape code 1), element i is read from address base+i, modulo 256.
- R3: For a column operand (shape code 2), element i is read from address base+8*i, modulo 256.
- R4: For a single-word operand (shape code 0), every element is read from the base address.
- R5: For a matrix operand (shape code 3), the elements are read from consecutive addresses starting at the base.
- R6: The result is the sum over i < count of A[i]*B[i], with both bytes unsigned, truncated to 16 bits (it wraps on overflow).
- R7: For count N >= 1, the low byte of the result is on `out_byte` with `out_valid` high in the cycle after the (N+1)th rising edge that follows the edge sampling start. The high byte follows in the next cycle, with `out_valid` and a one-cycle `done`.
- R8: Each bank's read enable is high for exactly N consecutive cycles, starting in the cycle after start is sampled.
- R9: A count of 0 yields the result 0x0000, with the low byte driven from the edge that samples start and the high byte with done one cycle later.
- R10: A start pulse raised while an operation is in progress is ignored. The running result, its timing and the read count are unchanged, and no further output follows.
- R11: The accumulator is cleared on every accepted start, so a result never depends on an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| base_a | input | 8 | First address of operand in bank A |
| shape_a | input | 2 | Walk of operand A: 0 word, 1 row, 2 column, 3 matrix |
| base_b | input | 8 | First address of operand in bank B |
| shape_b | input | 2 | Walk of operand B, same encoding |
| count | input | 4 | Number of multiply-accumulate steps |
| a_rd_en | output | 1 | Read enable for bank A |
| a_addr | output | 8 | Read address for bank A |
| a_rdata | input | 8 | Bank A data, one cycle after the enable |
| b_rd_en | output | 1 | Read enable for bank B |
| b_addr | output | 8 | Read address for bank B |
| b_rdata | input | 8 | Bank B data, one cycle after the enable |
| out_valid | output | 1 | Output byte is valid |
| out_byte | output | 8 | Result byte, low byte first |
| done | output | 1 | Marks the high byte of the result |

## Verification
For each read cycle, the address on each bank is compared in that same cycle with the bench's own stride arithmetic. The read enables are counted to show that exactly N reads occur, beginning one cycle after start. For count N >= 1, the low result byte is due N+2 sampling points after the start edge. The high byte and done are due one sampling point after the low byte, and for a zero count both move up to the first and second sampling points. The bench drives inputs and samples outputs on falling edges, numbers each sampling point from the start edge, and compares the recorded index of every event with these expected indices rather than simply waiting for done.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [1:0] {
    SHP_WORD = 2'd0,
    SHP_ROW  = 2'd1,
    SHP_COL  = 2'd2,
    SHP_MAT  = 2'd3
  } shape_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_HI
  } state_e;

  // address increment per element for a given operand walk
  function automatic int unsigned stride_of(shape_e s, int unsigned mat_w);
    case (s)
      SHP_WORD: return 0;
      SHP_COL:  return mat_w;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/vmac_addr_gen.sv
module vmac_addr_gen
  import vmac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int MAT_W  = 8
) (
  input  shape_e              shape,
  input  logic [ADDR_W-1:0]   base,
  input  logic [CNT_W-1:0]    idx,
  output logic [ADDR_W-1:0]   addr
);
  localparam int PW = ADDR_W + CNT_W;

  logic [PW-1:0] offs;

  always_comb begin
    offs = PW'(stride_of(shape, MAT_W)) * PW'(idx);
    addr = base + offs[ADDR_W-1:0];
  end

endmodule

// File: rtl/vmac_accum.sv
module vmac_accum #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  acc_nx
);
  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] mac_add(logic [ACC_W-1:0] acc,
                                               logic [DATA_W-1:0] a,
                                               logic [DATA_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b);
    return acc + ACC_W'(p);
  endfunction

  always_comb begin
    if (clear)   acc_nx = '0;
    else if (en) acc_nx = mac_add(acc_q, op_a, op_b);
    else         acc_nx = acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nx;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_q == '0) else $error("accumulator not cleared"); // R11

endmodule

// File: rtl/vmac_stream_unit.sv
module vmac_stream_unit
  import vmac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int MAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [1:0]        shape_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [1:0]        shape_b,
  input  logic [CNT_W-1:0]  count,
  output logic              a_rd_en,
  output logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_rdata,
  output logic              b_rd_en,
  output logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              done
);
  localparam int ACC_W = 2 * DATA_W;

  state_e            state;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_a_q, base_b_q;
  shape_e            shape_a_q, shape_b_q;
  logic              rd_vld;
  logic [ACC_W-1:0]  acc_q, acc_nx;

  // named internal events
  logic start_take;
  logic issue_fire;
  logic last_issue;
  logic result_lo_fire;

  assign start_take     = start && (state == ST_IDLE);
  assign issue_fire     = (state == ST_RUN);
  assign last_issue     = issue_fire && (idx == cnt_q - 1'b1);
  assign result_lo_fire = (state == ST_WAIT);

  vmac_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAT_W(MAT_W)) u_agen_a (
    .shape(shape_a_q), .base(base_a_q), .idx(idx), .addr(a_addr)
  );

  vmac_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAT_W(MAT_W)) u_agen_b (
    .shape(shape_b_q), .base(base_b_q), .idx(idx), .addr(b_addr)
  );

  vmac_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(start_take), .en(rd_vld),
    .op_a(a_rdata), .op_b(b_rdata), .acc_q(acc_q), .acc_nx(acc_nx)
  );

  assign a_rd_en = issue_fire;
  assign b_rd_en = issue_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      cnt_q     <= '0;
      base_a_q  <= '0;
      base_b_q  <= '0;
      shape_a_q <= SHP_WORD;
      shape_b_q <= SHP_WORD;
      rd_vld    <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      rd_vld    <= issue_fire;
      case (state)
        ST_IDLE: if (start_take) begin
          cnt_q     <= count;
          base_a_q  <= base_a;
          base_b_q  <= base_b;
          shape_a_q <= shape_e'(shape_a);
          shape_b_q <= shape_e'(shape_b);
          idx       <= '0;
          if (count == '0) begin
            state     <= ST_HI;
            out_valid <= 1'b1;
            out_byte  <= '0;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          idx <= idx + 1'b1;
          if (last_issue) state <= ST_WAIT;
        end
        ST_WAIT: if (result_lo_fire) begin
          state     <= ST_HI;
          out_valid <= 1'b1;
          out_byte  <= acc_nx[DATA_W-1:0];
        end
        default: begin
          state     <= ST_IDLE;
          out_valid <= 1'b1;
          out_byte  <= acc_q[ACC_W-1:DATA_W];
          done      <= 1'b1;
        end
      endcase
    end
  end

  AST_READ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_rd_en) |-> $past(start)) else $error("read without start"); // R8
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_en && $past(b_rd_en) && shape_b_q == SHP_ROW)
      |-> b_addr == $past(b_addr) + ADDR_W'(1)) else $error("row stride"); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && $past(a_rd_en) && shape_a_q == SHP_COL)
      |-> a_addr == $past(a_addr) + ADDR_W'(MAT_W)) else $error("col stride"); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && $past(a_rd_en) && shape_a_q == SHP_WORD)
      |-> $stable(a_addr)) else $error("word moved"); // R4
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> (out_valid && done)) else $error("no high byte"); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cnt_q) && $stable(base_a_q)) else $error("relatched"); // R10

endmodule

// File: tb/tb_vmac_stream_unit.sv
module tb_vmac_stream_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] base_a = '0, base_b = '0;
  logic [1:0] shape_a = '0, shape_b = '0;
  logic [3:0] count = '0;
  logic       a_rd_en, b_rd_en, out_valid, done;
  logic [7:0] a_addr, b_addr, out_byte;
  logic [7:0] a_rdata = '0, b_rdata = '0;

  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmac_stream_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_a(base_a), .shape_a(shape_a), .base_b(base_b), .shape_b(shape_b),
    .count(count),
    .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_rd_en(b_rd_en), .b_addr(b_addr), .b_rdata(b_rdata),
    .out_valid(out_valid), .out_byte(out_byte), .done(done)
  );

  always @(posedge clk) begin
    if (a_rd_en) a_rdata <= mem_a[a_addr];
    if (b_rd_en) b_rdata <= mem_b[b_addr];
  end

  // {base_a, shape_a, base_b, shape_b, count}
  localparam logic [23:0] VEC [0:7] = '{
    {8'd0,   2'd1, 8'd0,   2'd2, 4'd8},
    {8'd16,  2'd1, 8'd3,   2'd2, 4'd8},
    {8'd5,   2'd2, 8'd40,  2'd1, 4'd8},
    {8'd255, 2'd0, 8'd255, 2'd0, 4'd15},
    {8'd100, 2'd3, 8'd200, 2'd3, 4'd12},
    {8'd250, 2'd1, 8'd200, 2'd2, 4'd8},
    {8'd7,   2'd1, 8'd9,   2'd1, 4'd1},
    {8'd0,   2'd2, 8'd33,  2'd0, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [1:0] s);
    return (s == 2'd0) ? 0 : (s == 2'd2) ? 8 : 1;
  endfunction

  function automatic logic [7:0] ea(input logic [7:0] b, input logic [1:0] s, input int i);
    return 8'((int'(b) + step_of(s) * i) % 256);
  endfunction

  function automatic string shape_req(input logic [1:0] s);
    case (s)
      2'd0: return "R4";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] ba, input logic [1:0] sa,
                         input logic [7:0] bb, input logic [1:0] sb,
                         input logic [3:0] n, input bit inject, output int res);
    int exp_sum = 0;
    int en_cnt = 0;
    int n_out = 0;
    int lo_j = -1, hi_j = -1, done_j = -1;
    int lo_b = 0, hi_b = 0;
    bit a_ok = 1, b_ok = 1;
    int exp_lo_j;
    for (int i = 0; i < int'(n); i++)
      exp_sum += int'(mem_a[ea(ba, sa, i)]) * int'(mem_b[ea(bb, sb, i)]);
    exp_sum = exp_sum % 65536;
    exp_lo_j = (n == 0) ? 1 : int'(n) + 2;
    @(negedge clk);
    base_a = ba; shape_a = sa; base_b = bb; shape_b = sb; count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= int'(n) + 6; j++) begin
      if (a_rd_en) begin
        if (a_addr != ea(ba, sa, en_cnt)) a_ok = 0;
        if (b_addr != ea(bb, sb, en_cnt)) b_ok = 0;
        en_cnt++;
      end
      if (b_rd_en != a_rd_en) b_ok = 0;
      if (out_valid) begin
        if (n_out == 0) begin lo_b = out_byte; lo_j = j; end
        else if (n_out == 1) begin hi_b = out_byte; hi_j = j; end
        n_out++;
      end
      if (done) done_j = j;
      if (inject && j == 2) begin
        base_a = 8'd77; shape_a = 2'd0; base_b = 8'd1; count = 4'd3; start = 1'b1;
      end
      if (inject && j == 4) start = 1'b0;
      @(negedge clk);
    end
    res = hi_b * 256 + lo_b;
    chk(res == exp_sum, inject ? "R10 result" : "R6 result", res, exp_sum);
    chk(lo_j == exp_lo_j, (n == 0) ? "R9 low byte cycle" : "R7 low byte cycle", lo_j, exp_lo_j);
    chk(hi_j == lo_j + 1 && done_j == hi_j, "R7 high byte with done", done_j, lo_j + 1);
    chk(n_out == 2, inject ? "R10 output count" : "R7 output count", n_out, 2);
    chk(en_cnt == int'(n), "R8 read count", en_cnt, int'(n));
    if (n != 0) begin
      chk(a_ok, shape_req(sa), 0, 1);
      chk(b_ok, shape_req(sb), 0, 1);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int r0, r1;
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = 8'((i * 37 + 11) % 256);
      mem_b[i] = 8'((i * 91 + 5) % 256);
    end
    mem_a[255] = 8'hFF;
    mem_b[255] = 8'hFF;

    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    chk(!out_valid && !done && !a_rd_en && !b_rd_en, "R1 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && !a_rd_en && !b_rd_en, "R1 after reset", int'(done), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      int r;
      run_vec(VEC[v][23:16], VEC[v][15:14], VEC[v][13:6], VEC[v][5:4], VEC[v][3:0], 1'b0, r);
    end

    // R9 zero count
    run_vec(8'd12, 2'd1, 8'd12, 2'd2, 4'd0, 1'b0, r0);
    chk(r0 == 0, "R9 zero result", r0, 0);

    // R10 start during busy is ignored
    run_vec(8'd20, 2'd1, 8'd2, 2'd2, 4'd8, 1'b1, r0);

    // R11 accumulator cleared: identical operation after a large one
    run_vec(8'd255, 2'd0, 8'd255, 2'd0, 4'd15, 1'b0, r0);
    run_vec(8'd7, 2'd1, 8'd9, 2'd1, 4'd1, 1'b0, r1);
    chk(r1 == int'(mem_a[7]) * int'(mem_b[9]), "R11 cleared between ops", r1,
        int'(mem_a[7]) * int'(mem_b[9]));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule